// File: doc/BRIEF.md
# External Memory Address Mode Router

This block sits between a microcontroller core and its data-memory paths. Each cycle it may receive one data-memory access request. The request is either a short indirect access or a wide pointer access. A short access takes its upper address byte from a page register and its lower byte from an index register. A wide access takes all sixteen address bits from the data pointer. The block forms the effective address. It then decides whether the access goes to the 4 KB on-chip RAM or to the external memory bus, following a 2-bit mode input. It also drives the external address with a separate output-enable flag for each byte.

The routing result is held in a small registered state machine. The states are:

- `ST_IDLE`: no request.
- `ST_ONCHIP`: the access goes to on-chip RAM.
- `ST_OFF_LOW`: the access goes off-chip and only the low address byte is driven.
- `ST_OFF_FULL`: the access goes off-chip and both address bytes are driven.

Every state can move to every other state on each clock edge:

- With no request, the machine goes to `ST_IDLE`.
- In internal-only mode, a request goes to `ST_ONCHIP`.
- In external-only mode, a request goes to `ST_OFF_FULL`.
- In the two split modes, a request whose address is below 0x1000 goes to `ST_ONCHIP`.
- In split mode with bank select, a request at or above 0x1000 goes to `ST_OFF_FULL`.
- In split mode without bank select, a wide access at or above 0x1000 goes to `ST_OFF_FULL`.
- In split mode without bank select, a short access at or above 0x1000 goes to `ST_OFF_LOW`. The upper address pins are then left to port logic.

Top module: `xmem_route`

## Requirements
- R1: While reset is asserted, `out_valid`, `sel_offchip`, `ext_lo_oe`, `ext_hi_oe`, `onchip_addr` and `ext_addr` are all zero.
- R2: Outputs are registered. A request sampled at a clock edge sets `out_valid` after that edge. A cycle without `req_valid` returns every output to zero after the next edge.
- R3: The effective address is `{page_hi, idx_lo}` when `req_wide` = 0, and `dptr` when `req_wide` = 1.
- R4: With `mode` = 2'b00 (internal only), every access is on-chip: `sel_offchip` = 0 and both enables are 0, even when the address is 0x1000 or 0x2000.
- R5: With `mode` = 2'b01 or 2'b10 (split), an effective address below 0x1000 is on-chip. An address of 0x1000 or above is off-chip (`sel_offchip` = 1).
- R6: With `mode` = 2'b01, an off-chip short access drives only the low byte. `ext_lo_oe` = 1, `ext_hi_oe` = 0, `ext_addr[7:0]` = `idx_lo`, and `ext_addr[15:8]` = 0.
- R7: With `mode` = 2'b10, an off-chip short access sets both enables, and `ext_addr` = `{page_hi, idx_lo}`.
- R8: Any off-chip wide access sets both enables, and `ext_addr` = `dptr`.
- R9: With `mode` = 2'b11 (external only), every access is off-chip with both enables set, including address 0x0000.
- R10: For every request, in every mode, `onchip_addr` equals the effective address modulo 4096.
- R11: When a request goes on-chip, `ext_addr` is 0 and neither enable is set. `ext_hi_oe` is never set without `ext_lo_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | An access request is present this cycle |
| req_wide | input | 1 | 1 = 16-bit pointer access, 0 = short indirect access |
| mode | input | 2 | Routing mode: 00 internal, 01 split without bank, 10 split with bank, 11 external |
| page_hi | input | 8 | Page register, the upper byte of a short access |
| idx_lo | input | 8 | Index register, the lower byte of a short access |
| dptr | input | 16 | Data pointer, the address of a wide access |
| out_valid | output | 1 | A routed access is presented |
| sel_offchip | output | 1 | 1 = off-chip, 0 = on-chip |
| onchip_addr | output | 12 | On-chip RAM address (effective address modulo 4 KB) |
| ext_addr | output | 16 | External address bus value |
| ext_lo_oe | output | 1 | Drive enable for `ext_addr[7:0]` |
| ext_hi_oe | output | 1 | Drive enable for `ext_addr[15:8]` |

## Verification
The hardest case to reach is the edge of the split boundary: a short access whose page byte is exactly 0x0F or 0x10, in a split mode, with the request width changing from one cycle to the next. Uniform random addresses almost never land there. The stimulus therefore draws about half of its addresses from a small set around 0x0FFF/0x1000 and at the wrap points 0x2000 and 0xFFFF. It also picks the mode and the request width independently on every cycle, so that back-to-back requests move between all four states. Directed cases cover the wrap examples and reset first.

// File: rtl/xmr_pkg.sv
package xmr_pkg;

    typedef enum logic [1:0] {
        MODE_INT_ONLY     = 2'b00,
        MODE_SPLIT_NOBANK = 2'b01,
        MODE_SPLIT_BANK   = 2'b10,
        MODE_EXT_ONLY     = 2'b11
    } xmr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_ONCHIP   = 2'b01,
        ST_OFF_LOW  = 2'b10,
        ST_OFF_FULL = 2'b11
    } xmr_state_e;

endpackage

// File: rtl/xmr_ea_former.sv
module xmr_ea_former #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              wide,
    input  logic [BYTE_W-1:0] page,
    input  logic [BYTE_W-1:0] idx,
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] ea
);
    localparam int PAIR_W = 2 * BYTE_W;

    logic [ADDR_W-1:0] short_ea;

    generate
        if (ADDR_W == PAIR_W) begin : g_exact
            assign short_ea = {page, idx};
        end else if (ADDR_W > PAIR_W) begin : g_pad
            assign short_ea = {{(ADDR_W-PAIR_W){1'b0}}, page, idx};
        end else begin : g_trim
            logic [PAIR_W-1:0] pair;
            assign pair     = {page, idx};
            assign short_ea = pair[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        ea = wide ? ptr : short_ea;
    end
endmodule

// File: rtl/xmr_region_decode.sv
module xmr_region_decode
    import xmr_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int ONCHIP_W = 12
) (
    input  logic              valid,
    input  logic              wide,
    input  xmr_mode_e         mode,
    input  logic [ADDR_W-1:0] ea,
    output xmr_state_e        next_state
);
    localparam int HIGH_W = ADDR_W - ONCHIP_W;

    logic below_boundary;
    logic [HIGH_W-1:0] high_part;

    assign high_part      = ea[ADDR_W-1:ONCHIP_W];
    assign below_boundary = (high_part == '0);

    always_comb begin
        next_state = ST_IDLE;
        if (valid) begin
            unique case (mode)
                MODE_INT_ONLY:     next_state = ST_ONCHIP;
                MODE_SPLIT_NOBANK: next_state = below_boundary ? ST_ONCHIP
                                               : (wide ? ST_OFF_FULL : ST_OFF_LOW);
                MODE_SPLIT_BANK:   next_state = below_boundary ? ST_ONCHIP : ST_OFF_FULL;
                MODE_EXT_ONLY:     next_state = ST_OFF_FULL;
            endcase
        end
    end
endmodule

// File: rtl/xmem_route.sv
module xmem_route
    import xmr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int ONCHIP_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_wide,
    input  logic [1:0]            mode,
    input  logic [BYTE_W-1:0]     page_hi,
    input  logic [BYTE_W-1:0]     idx_lo,
    input  logic [2*BYTE_W-1:0]   dptr,
    output logic                  out_valid,
    output logic                  sel_offchip,
    output logic [ONCHIP_W-1:0]   onchip_addr,
    output logic [2*BYTE_W-1:0]   ext_addr,
    output logic                  ext_lo_oe,
    output logic                  ext_hi_oe
);
    localparam int ADDR_W = 2 * BYTE_W;

    xmr_state_e        state_q;
    xmr_state_e        state_d;
    logic [ADDR_W-1:0] ea;
    logic [ADDR_W-1:0] ext_q;
    logic [ONCHIP_W-1:0] onchip_q;

    xmr_ea_former #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) i_ea (
        .wide (req_wide),
        .page (page_hi),
        .idx  (idx_lo),
        .ptr  (dptr),
        .ea   (ea)
    );

    xmr_region_decode #(.ADDR_W(ADDR_W), .ONCHIP_W(ONCHIP_W)) i_dec (
        .valid      (req_valid),
        .wide       (req_wide),
        .mode       (xmr_mode_e'(mode)),
        .ea         (ea),
        .next_state (state_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers, loaded according to the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q    <= '0;
            onchip_q <= '0;
        end else begin
            onchip_q <= req_valid ? ea[ONCHIP_W-1:0] : '0;
            unique case (state_d)
                ST_OFF_FULL: ext_q <= ea;
                ST_OFF_LOW:  ext_q <= {{(ADDR_W-BYTE_W){1'b0}}, ea[BYTE_W-1:0]};
                ST_ONCHIP:   ext_q <= '0;
                ST_IDLE:     ext_q <= '0;
            endcase
        end
    end

    assign out_valid   = (state_q != ST_IDLE);
    assign sel_offchip = (state_q == ST_OFF_LOW) || (state_q == ST_OFF_FULL);
    assign ext_lo_oe   = sel_offchip;
    assign ext_hi_oe   = (state_q == ST_OFF_FULL);
    assign onchip_addr = onchip_q;
    assign ext_addr    = ext_q;

    AST_REQ_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && ext_addr == '0 && onchip_addr == '0)); // R2
    AST_INT_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b00) |=> (!sel_offchip && !ext_lo_oe)); // R4
    AST_EXT_GOES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b11) |=> (sel_offchip && ext_hi_oe)); // R9
    AST_NOBANK_HI_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b01 && !req_wide) |=> !ext_hi_oe); // R6
    AST_WIDE_LOW12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_wide) |=> (onchip_addr == $past(dptr[ONCHIP_W-1:0]))); // R10
    AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hi_oe |-> ext_lo_oe); // R11
    AST_ONCHIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !sel_offchip) |-> (ext_addr == '0)); // R11
endmodule

// File: tb/test_xmem_route.sv
`timescale 1ns/1ps
module test_xmem_route;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_wide = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  page_hi = 8'h00;
    logic [7:0]  idx_lo = 8'h00;
    logic [15:0] dptr = 16'h0000;
    logic        out_valid, sel_offchip, ext_lo_oe, ext_hi_oe;
    logic [11:0] onchip_addr;
    logic [15:0] ext_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xmem_route i_xmem_route (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wide(req_wide),
        .mode(mode), .page_hi(page_hi), .idx_lo(idx_lo), .dptr(dptr),
        .out_valid(out_valid), .sel_offchip(sel_offchip), .onchip_addr(onchip_addr),
        .ext_addr(ext_addr), .ext_lo_oe(ext_lo_oe), .ext_hi_oe(ext_hi_oe)
    );

    function automatic logic [15:0] model_ea(logic w, logic [7:0] p, logic [7:0] i, logic [15:0] d);
        return w ? d : {p, i};
    endfunction

    // Packed expectation: {valid, off, lo, hi, onchip[11:0], ext[15:0]}
    function automatic logic [31:0] model_out(logic w, logic [1:0] m, logic [15:0] e);
        logic off, lo, hi;
        logic [15:0] x;
        off = (m == 2'b11) || ((m == 2'b01 || m == 2'b10) && e >= 16'h1000);
        lo  = off;
        hi  = off && !(m == 2'b01 && !w);
        x   = !off ? 16'h0000 : (hi ? e : {8'h00, e[7:0]});
        return {1'b1, off, lo, hi, e[11:0], x};
    endfunction

    function automatic string tag_for(logic w, logic [1:0] m, logic [15:0] e);
        logic off;
        off = (m == 2'b11) || ((m != 2'b00) && e >= 16'h1000);
        if (m == 2'b00) return "R4";
        if (m == 2'b11) return "R9";
        if (!off)       return "R5";
        if (w)          return "R8";
        if (m == 2'b01) return "R6";
        return "R7";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] observed();
        return {out_valid, sel_offchip, ext_lo_oe, ext_hi_oe, onchip_addr, ext_addr};
    endfunction

    task automatic do_req(logic w, logic [1:0] m, logic [7:0] p, logic [7:0] i, logic [15:0] d);
        logic [15:0] e;
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_wide = w; mode = m; page_hi = p; idx_lo = i; dptr = d;
        e   = model_ea(w, p, i, d);
        exp = model_out(w, m, e);
        @(posedge clk); #1;
        check(tag_for(w, m, e), observed(), exp);
        check("R10", {20'h0, onchip_addr}, {20'h0, e[11:0]});
        if (!exp[30]) check("R11", {15'h0, ext_hi_oe, ext_addr}, 32'h0);
    endtask

    task automatic do_idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_wide = 1'($urandom); mode = 2'($urandom); dptr = 16'($urandom);
        @(posedge clk); #1;
        check("R2", observed(), 32'h0);
    endtask

    function automatic logic [15:0] pick_addr();
        logic [2:0] k;
        k = 3'($urandom);
        case (k)
            3'd0: return 16'h0FFF;
            3'd1: return 16'h1000;
            3'd2: return 16'h2000;
            3'd3: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1", observed(), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R2", observed(), 32'h0);

        // R3: both ways of forming the address
        do_req(1'b0, 2'b10, 8'h12, 8'h34, 16'hABCD);
        check("R3", {16'h0, ext_addr}, 32'h0000_1234);
        do_req(1'b1, 2'b10, 8'h12, 8'h34, 16'hABCD);
        check("R3", {16'h0, ext_addr}, 32'h0000_ABCD);
        // R4: wrap examples stay on-chip at 0x000
        do_req(1'b1, 2'b00, 8'h00, 8'h00, 16'h1000);
        check("R4", {20'h0, onchip_addr}, 32'h0);
        do_req(1'b1, 2'b00, 8'h00, 8'h00, 16'h2000);
        // R5 boundary, short and wide
        do_req(1'b0, 2'b01, 8'h0F, 8'hFF, 16'h0);
        do_req(1'b0, 2'b01, 8'h10, 8'h00, 16'h0);
        check("R6", {16'h0, ext_addr}, 32'h0000_0000);
        do_req(1'b0, 2'b10, 8'h10, 8'h00, 16'h0);
        check("R7", {30'h0, ext_lo_oe, ext_hi_oe}, 32'h3);
        do_req(1'b1, 2'b01, 8'h00, 8'h00, 16'h1000);
        do_req(1'b1, 2'b10, 8'h00, 8'h00, 16'h0FFF);
        // R9: address zero still off-chip
        do_req(1'b0, 2'b11, 8'h00, 8'h00, 16'h0);
        check("R9", {31'h0, sel_offchip}, 32'h1);
        do_idle();

        for (int n = 0; n < 600; n++) begin
            logic [15:0] a;
            if (($urandom % 8) == 0) begin
                do_idle();
            end else begin
                a = pick_addr();
                if ($urandom % 2) do_req(1'b1, 2'($urandom), 8'($urandom), 8'($urandom), a);
                else              do_req(1'b0, 2'($urandom), a[15:8], a[7:0], 16'($urandom));
            end
        end
        do_idle();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule